// File: doc/BRIEF.md
# I2C Slave Receiver with Buffer-Dependent Clock Stretching

This block is the receive side of an I2C target device. It watches the bus clock and data lines through a synchroniser and a short majority-style filter. It recognises START and STOP conditions and checks the 7-bit address byte against a programmed own address. It can also accept the general call address 0x00. Each data byte it receives is acknowledged by pulling SDA low for the ninth clock. Both bus lines are open-drain: the block only ever asserts an output-enable that pulls a line low.

Received bytes go to one of two stores, selected by a control bit. In queue mode, bytes enter an 8-entry FIFO. The bus clock is held low after the acknowledge-phase falling edge while the fill level is at or above a programmable trigger. A read that brings the fill level below the trigger releases the clock. In single-register mode, each byte lands in one holding register and raises a ready flag. The clock then stays low until software writes the flag back to 0. In both modes, a byte that finds no room is held before its acknowledge is driven, so nothing is overwritten. A plain byte-wide register port carries configuration, status and received data. Clearing the enable bit holds the whole bus-facing part in reset.

The byte engine has seven states:
- IDLE: waits for START.
- ADDR: shifts in the address byte.
- ADDR_ACK: drives the address acknowledge.
- DATA: shifts in a data byte.
- WAIT_ROOM: stretches the clock before the acknowledge because the store is full.
- DATA_ACK: drives the data acknowledge and stretches while the mode's hold condition is true.
- SKIP: ignores traffic not addressed to this device.

Transitions:
- START from any state goes to ADDR. STOP from any state goes to IDLE.
- ADDR goes to ADDR_ACK on a match, or to SKIP otherwise. This happens on the falling edge that ends the eighth bit.
- ADDR_ACK goes to DATA on the next falling edge.
- DATA goes to DATA_ACK (the byte is stored) or to WAIT_ROOM (no room) on the eighth-bit falling edge.
- WAIT_ROOM goes to DATA_ACK once room appears.
- DATA_ACK goes to DATA on the falling edge that ends the ninth clock.

Top module: `i2c_rx_stretch`

## Requirements
- R1: After reset, or while control bit 1 (enable) is 0, both line enables are deasserted, the FIFO count is 0, the ready flag is 0, and the byte engine is idle. Configuration registers are cleared only by the reset input.
- R2: Register map (3-bit address):
  - 0 is control: bit0 general-call enable, bit1 enable, bit2 mode (0 queue, 1 single).
  - 1 is own address, in bits 6:0.
  - 2 is the trigger level, in bits 3:0.
  - 3 is received data.
  - 4 is status: bit0 ready flag, bit1 full flag, bits 7:4 FIFO count.
  - Unused bits read 0 and writes to them have no effect.
- R3: An address byte whose upper 7 bits equal the own address and whose LSB is 0 (write) is acknowledged. The slave pulls SDA low during the ninth clock. Any other address, or a read request, gets no acknowledge.
- R4: Address byte 0x00 is acknowledged only when the general-call enable is 1.
- R5: In queue mode, every acknowledged data byte is stored. Reads of the data register return the bytes in arrival order, and each read removes one byte.
- R6: In queue mode, the full flag is 1 when the count is nonzero and at least the trigger level. While it is 1 in the acknowledge phase, SCL is held low. A data read that clears it releases SCL.
- R7: When the FIFO holds 8 bytes, the next byte is neither stored nor acknowledged until a read frees space. SCL is held low meanwhile, and no byte is lost.
- R8: In single mode, a received byte sets the ready flag and SCL is held low. Reading the data register does not release SCL, and neither does writing 1 to status bit0. Writing 0 to status bit0 clears the flag and releases SCL.
- R9: STOP, or a repeated START, returns the byte engine to idle or address phase and discards a partial byte. Stored bytes are kept. Bytes clocked while idle are not acknowledged.
- R10: A pulse of 2 system clocks or less on SCL or SDA has no effect on reception.
- R11: The slave changes its SDA enable only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_oe | output | 1 | Pull bus clock low when 1 |
| sda_oe | output | 1 | Pull bus data low when 1 |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops FIFO at address 3) |
| reg_rdata | output | 8 | Register read data |

## Verification
The checker watches, on every clock, that the FIFO count never exceeds its depth. It also checks that a disabled slave releases both lines and empties its stores, that the SDA enable moves only while the filtered clock is low, and that a stretch ends only once the hold condition of the current mode is false. The bench scenarios alone show address matching, general-call gating, arrival order of data, the stall on a full FIFO, glitch rejection, and recovery after STOP, repeated START or a mid-byte STOP. These need whole bus transfers and register reads to observe.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_WAIT_ROOM,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_e;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_OWN    = 3'd1;
    localparam logic [2:0] ADDR_TRIG   = 3'd2;
    localparam logic [2:0] ADDR_DATA   = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
    parameter int SAMPLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic dout
);
    logic [1:0]         sync_q;
    logic [SAMPLES-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else if (clr) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[SAMPLES-2:0], sync_q[1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic [CNT_W-1:0] count
);
    logic [DW-1:0] mem_q [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    assign do_push = push && (count != CNT_W'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign rdata   = mem_q[rd_q];

    always_ff @(posedge clk) begin
        if (do_push)
            mem_q[wr_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else if (clr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            count <= '0;
        end else begin
            if (do_push)
                wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (do_pop)
                rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (do_push && !do_pop)
                count <= count + 1'b1;
            else if (do_pop && !do_push)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/slave_fsm.sv
module slave_fsm
    import i2c_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [6:0] own_addr,
    input  logic       gc_en,
    input  logic       room,
    input  logic       hold,
    output logic       push,
    output logic [7:0] byte_out,
    output logic       scl_oe,
    output logic       sda_oe
);
    rx_state_e  state_q, state_d;
    logic [3:0] cnt_q, cnt_d;
    logic [7:0] shift_q, shift_d;
    logic       scl_d, sda_d;
    logic       scl_rise, scl_fall, start_c, stop_c, addr_hit;

    assign scl_rise = scl_f && !scl_d;
    assign scl_fall = !scl_f && scl_d;
    assign start_c  = scl_f && scl_d && sda_d && !sda_f;
    assign stop_c   = scl_f && scl_d && !sda_d && sda_f;
    assign addr_hit = !shift_q[0] &&
                      ((shift_q[7:1] == own_addr) || (shift_q[7:1] == 7'd0 && gc_en));
    assign byte_out = shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
        end else if (clr) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            scl_d   <= 1'b1;
            sda_d   <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
            scl_d   <= scl_f;
            sda_d   <= sda_f;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        shift_d = shift_q;
        push    = 1'b0;
        if (start_c) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else if (stop_c) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        shift_d = {shift_q[6:0], sda_f};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == 4'd8) begin
                        state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                    end
                end
                ST_ADDR_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        shift_d = {shift_q[6:0], sda_f};
                        cnt_d   = cnt_q + 1'b1;
                    end else if (scl_fall && cnt_q == 4'd8) begin
                        if (room) begin
                            push    = 1'b1;
                            state_d = ST_DATA_ACK;
                        end else begin
                            state_d = ST_WAIT_ROOM;
                        end
                    end
                end
                ST_WAIT_ROOM: begin
                    if (room) begin
                        push    = 1'b1;
                        state_d = ST_DATA_ACK;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        sda_oe = (state_q == ST_ADDR_ACK) || (state_q == ST_DATA_ACK);
        scl_oe = (state_q == ST_WAIT_ROOM) || (state_q == ST_DATA_ACK && hold);
    end
endmodule

// File: rtl/i2c_rx_stretch.sv
module i2c_rx_stretch
    import i2c_rx_pkg::*;
#(
    parameter int FIFO_DEPTH   = 8,
    parameter int TRIG_W       = 4,
    parameter int FILT_SAMPLES = 3,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    input  logic       reg_rd,
    output logic [7:0] reg_rdata
);
    logic              gc_en_q, en_q, single_q, dready_q;
    logic [6:0]        own_q;
    logic [TRIG_W-1:0] trig_q;
    logic [7:0]        sbuf_q, rx_byte, fifo_rdata;
    logic [CNT_W-1:0]  fifo_count;
    logic              clr, scl_filt, sda_filt, push, room, hold, rx_full, pop;
    logic              unused_wbits;

    assign clr          = !en_q;
    assign unused_wbits = reg_wdata[7];
    assign rx_full      = !single_q && (fifo_count != '0) && (int'(fifo_count) >= int'(trig_q));
    assign room         = single_q ? !dready_q : (fifo_count != CNT_W'(FIFO_DEPTH));
    assign hold         = single_q ? dready_q : rx_full;
    assign pop          = reg_rd && (reg_addr == ADDR_DATA) && !single_q;

    line_filter #(.SAMPLES(FILT_SAMPLES)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .din(scl_i), .dout(scl_filt));
    line_filter #(.SAMPLES(FILT_SAMPLES)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .din(sda_i), .dout(sda_filt));

    slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(clr), .scl_f(scl_filt), .sda_f(sda_filt),
        .own_addr(own_q), .gc_en(gc_en_q), .room(room), .hold(hold),
        .push(push), .byte_out(rx_byte), .scl_oe(scl_oe), .sda_oe(sda_oe));

    rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(8)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push && !single_q), .wdata(rx_byte),
        .pop(pop), .rdata(fifo_rdata), .count(fifo_count));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gc_en_q  <= 1'b0;
            en_q     <= 1'b0;
            single_q <= 1'b0;
            own_q    <= '0;
            trig_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) begin
                gc_en_q  <= reg_wdata[0];
                en_q     <= reg_wdata[1];
                single_q <= reg_wdata[2];
            end
            if (reg_addr == ADDR_OWN)
                own_q <= reg_wdata[6:0];
            if (reg_addr == ADDR_TRIG)
                trig_q <= reg_wdata[TRIG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sbuf_q   <= '0;
            dready_q <= 1'b0;
        end else if (clr) begin
            dready_q <= 1'b0;
        end else if (push && single_q) begin
            sbuf_q   <= rx_byte;
            dready_q <= 1'b1;
        end else if (reg_wr && reg_addr == ADDR_STATUS && !reg_wdata[0]) begin
            dready_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:   reg_rdata = {5'b0, single_q, en_q, gc_en_q};
            ADDR_OWN:    reg_rdata = 8'(own_q);
            ADDR_TRIG:   reg_rdata = 8'(trig_q);
            ADDR_DATA:   reg_rdata = single_q ? sbuf_q : fifo_rdata;
            ADDR_STATUS: reg_rdata = {4'(fifo_count), 2'b0, rx_full, dready_q};
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             single,
    input logic             scl_f,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             dready,
    input logic             rx_full,
    input logic [CNT_W-1:0] count
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH); // R7

    AST_DISABLED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe && count == '0 && !dready)); // R1

    AST_SDA_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n || !en)
        $rose(sda_oe) |-> !scl_f); // R11

    AST_SDA_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n || !en)
        $fell(sda_oe) |-> !scl_f); // R11

    AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (single && $fell(scl_oe)) |-> !dready); // R8

    AST_QUEUE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (!single && $fell(scl_oe)) |-> !rx_full); // R6
endmodule

bind i2c_rx_stretch i2c_rx_checker #(.DEPTH(FIFO_DEPTH)) u_checker (
    .clk(clk), .rst_n(rst_n), .en(en_q), .single(single_q), .scl_f(scl_filt),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .dready(dready_q), .rx_full(rx_full),
    .count(fifo_count));

// File: tb/test_i2c_rx_stretch.sv
`timescale 1ns/1ps
module test_i2c_rx_stretch;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1, scl_glitch = 1'b0;
    logic       scl_oe, sda_oe;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       scl_line, sda_line;
    int         checks = 0, errors = 0;
    bit         may_stretch = 1'b0;
    bit         done = 1'b0;
    byte unsigned exp_q[$];

    assign scl_line = m_scl && !scl_oe;
    assign sda_line = m_sda && !sda_oe;

    always #2.5 clk = ~clk;

    i2c_rx_stretch i_i2c_rx_stretch (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line && !scl_glitch), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata));

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Per-clock model comparison: SCL may only be stretched where the model expects it (R6, R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (scl_oe && !may_stretch) begin
                errors++;
                $display("FAIL R6/R8 unexpected stretch: actual %0d expected 0", scl_oe);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_reg(logic [2:0] a, logic [7:0] e, string req);
        logic [7:0] d;
        reg_read(a, d);
        chk(d == e, req, d, e);
    endtask

    task automatic expect_pop(string req);
        logic [7:0] d;
        byte unsigned e;
        e = exp_q.pop_front();
        reg_read(3'd3, d);
        chk(d == e, req, d, e);
    endtask

    task automatic wait_scl_high();
        int w = 0;
        while (!scl_line && w < 5000) begin
            @(negedge clk);
            w++;
        end
    endtask

    task automatic send_bit(bit b, bit glitch);
        m_sda = b; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        if (glitch) begin
            scl_glitch = 1'b1; tick(2); scl_glitch = 1'b0;
        end
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send8(logic [7:0] b, int glitch_at);
        for (int i = 7; i >= 0; i--)
            send_bit(b[i], i == glitch_at);
    endtask

    task automatic ack_clk(output bit ack);
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        ack = !sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic write_byte(logic [7:0] b, bit exp_ack, string req);
        bit a;
        send8(b, -1);
        ack_clk(a);
        chk(a == exp_ack, req, a, exp_ack);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; wait_scl_high(); tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        bit a;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk(!scl_oe && !sda_oe, "R1 reset lines", {scl_oe, sda_oe}, 0);
        expect_reg(3'd0, 8'h00, "R1 reset control");
        expect_reg(3'd4, 8'h00, "R1 reset status");

        // R2: reserved bits read zero
        reg_write(3'd0, 8'hFF);
        expect_reg(3'd0, 8'h07, "R2 control reserved");
        reg_write(3'd1, 8'hAA);
        expect_reg(3'd1, 8'h2A, "R2 own addr reserved");
        reg_write(3'd2, 8'hF3);
        expect_reg(3'd2, 8'h03, "R2 trigger reserved");
        reg_write(3'd0, 8'h02);

        // R3: address matching; R4: general call disabled
        bus_start(); write_byte(8'h2A, 1'b0, "R3 wrong address nack"); bus_stop();
        bus_start(); write_byte(8'h55, 1'b0, "R3 read request nack"); bus_stop();
        bus_start(); write_byte(8'h00, 1'b0, "R4 general call disabled"); bus_stop();

        // R5/R6: trigger level 3
        bus_start(); write_byte(8'h54, 1'b1, "R3 own address ack");
        exp_q.push_back(8'hA1); write_byte(8'hA1, 1'b1, "R5 byte ack");
        exp_q.push_back(8'hB2); write_byte(8'hB2, 1'b1, "R5 byte ack");
        exp_q.push_back(8'hC3);
        may_stretch = 1'b1;
        send8(8'hC3, -1); tick(30);
        chk(scl_oe, "R6 stretch at trigger", scl_oe, 1);
        expect_reg(3'd4, 8'h32, "R6 status count and full flag");
        expect_pop("R5 first byte");
        tick(3);
        chk(!scl_oe, "R6 release after read", scl_oe, 0);
        may_stretch = 1'b0;
        ack_clk(a); chk(a, "R6 ack after release", a, 1);
        bus_stop();
        expect_pop("R5 order"); expect_pop("R5 order");
        expect_reg(3'd4, 8'h00, "R5 drained status");

        // R7: full FIFO with unreachable trigger
        reg_write(3'd2, 8'h0F);
        bus_start(); write_byte(8'h54, 1'b1, "R3 own address ack");
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(byte'(8'h10 + i));
            write_byte(8'h10 + 8'(i), 1'b1, "R7 fill ack");
        end
        exp_q.push_back(8'h99);
        may_stretch = 1'b1;
        send8(8'h99, -1); tick(30);
        chk(scl_oe, "R7 stretch when full", scl_oe, 1);
        chk(!sda_oe, "R7 no ack while full", sda_oe, 0);
        expect_reg(3'd4, 8'h80, "R7 count eight");
        expect_pop("R7 oldest byte");
        tick(3);
        chk(!scl_oe, "R7 release after space", scl_oe, 0);
        chk(sda_oe, "R7 ack driven after store", sda_oe, 1);
        may_stretch = 1'b0;
        ack_clk(a); chk(a, "R7 late ack", a, 1);
        bus_stop();
        for (int i = 0; i < 8; i++) expect_pop("R7 no byte lost");

        // R9/R10: mid-byte stop, idle traffic, glitch, repeated start
        reg_write(3'd2, 8'h08);
        bus_start(); write_byte(8'h54, 1'b1, "R3 own address ack");
        exp_q.push_back(8'h5C); write_byte(8'h5C, 1'b1, "R9 byte before stop");
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
        bus_stop();
        write_byte(8'h54, 1'b0, "R9 idle ignores bytes");
        bus_stop();
        bus_start(); write_byte(8'h54, 1'b1, "R9 ack after mid-byte stop");
        exp_q.push_back(8'h3C);
        send8(8'h3C, 3); ack_clk(a); chk(a, "R10 glitched byte ack", a, 1);
        bus_start(); write_byte(8'h54, 1'b1, "R9 repeated start ack");
        exp_q.push_back(8'h7E); write_byte(8'h7E, 1'b1, "R9 byte after repeated start");
        bus_stop();
        expect_reg(3'd4, 8'h30, "R9 count kept");
        expect_pop("R9 kept byte"); expect_pop("R10 glitch filtered byte"); expect_pop("R9 byte");

        // R4: general call enabled
        reg_write(3'd0, 8'h03);
        bus_start(); write_byte(8'h00, 1'b1, "R4 general call ack");
        exp_q.push_back(8'h47); write_byte(8'h47, 1'b1, "R4 general call data");
        bus_stop();
        expect_pop("R4 general call byte");

        // R8: single mode
        reg_write(3'd0, 8'h06);
        bus_start(); write_byte(8'h54, 1'b1, "R3 own address ack");
        may_stretch = 1'b1;
        send8(8'h5A, -1); tick(30);
        chk(scl_oe, "R8 stretch on landing", scl_oe, 1);
        expect_reg(3'd4, 8'h01, "R8 ready flag set");
        expect_reg(3'd3, 8'h5A, "R8 single data");
        tick(3); chk(scl_oe, "R8 read keeps stretch", scl_oe, 1);
        reg_write(3'd4, 8'h01);
        tick(3); chk(scl_oe, "R8 write one ignored", scl_oe, 1);
        reg_write(3'd4, 8'h00);
        tick(3); chk(!scl_oe, "R8 release on clear", scl_oe, 0);
        may_stretch = 1'b0;
        ack_clk(a); chk(a, "R8 ack after clear", a, 1);
        bus_stop();
        expect_reg(3'd4, 8'h00, "R8 flag clear");

        // R1: disable while stretched
        reg_write(3'd0, 8'h02);
        reg_write(3'd2, 8'h01);
        bus_start(); write_byte(8'h54, 1'b1, "R3 own address ack");
        may_stretch = 1'b1;
        send8(8'h11, -1); tick(30);
        chk(scl_oe, "R1 stretched before disable", scl_oe, 1);
        reg_write(3'd0, 8'h00);
        tick(2);
        chk(!scl_oe && !sda_oe, "R1 disable releases lines", {scl_oe, sda_oe}, 0);
        expect_reg(3'd4, 8'h00, "R1 disable empties FIFO");
        reg_write(3'd0, 8'h02);
        may_stretch = 1'b0;
        bus_stop();
        bus_start(); write_byte(8'h54, 1'b1, "R1 works after re-enable"); bus_stop();

        tick(10);
        finish_run();
    end
endmodule